// File: doc/BRIEF.md
# GPIO Port with Pad Control

This block is a general-purpose I/O port for up to 32 pins. Software reaches it through a simple register bus. A write takes effect at the next clock edge, and a read returns its data combinationally in the same cycle.

Each pin holds the following state:
- an output-data bit;
- a direction bit;
- a two-bit alternate-function selection;
- a pull-disable bit;
- a sleep-policy bit.

From this state the block drives the pad controls for each pin: output enable, output value, pull enable, pull direction and a two-bit function code.

Set and clear aliases on the output-data and direction registers let software change single pins without a read-modify-write. A read of the data register returns the real pin levels after a two-flop synchronizer, whether the pin is an input or an output. While the sleep input is high, every pin whose sleep-policy bit is 0 is forced to a safe state: input, with its pull on. The stored configuration is not altered, so the pins return to their configured state when sleep is released.

Top module: `gpio_pad_port`

## Requirements
- R1: After reset, all pins are inputs (pad_oe = 0) and output data is 0. All pulls are on (pad_pull_en all ones). Every function code is 00. The pull-disable, sleep-policy and both function registers read back as 0.
- R2: Writing the data set alias (word offset 0x04) sets every output-data bit whose written bit is 1. Writing the data clear alias (0x08) clears every output-data bit whose written bit is 1. Bits written as 0 keep their value. A write to offset 0x00 loads output data directly. pad_out shows output data from the cycle after the write.
- R3: Writing the direction set alias (0x14) sets the addressed direction bits, and writing the direction clear alias (0x18) clears them. A write to 0x10 loads the direction register directly. A direction bit of 1 drives that pin's pad_oe high when sleep is not in effect. Offset 0x10 reads back the direction register.
- R4: A read of offset 0x00 returns pin_in as registered through two flops. A level applied to pin_in appears on the read data after the second rising edge, not after the first.
- R5: Two function registers are used: A at 0x20 and B at 0x24. Pin i drives pad_func[2i+1:2i] = {B[i], A[i]}. The code 00 means GPIO, 01 means function A, 10 means function B and 11 means function C.
- R6: Pull enable is the inverse of the pull-disable register at 0x0C, where a 1 turns the pull off. Pull direction pad_pull_up equals the pin's output-data bit: 1 means pull-up and 0 means pull-down.
- R7: While sleep_req is high, every pin whose sleep-policy bit (register 0x1C) is 0 has pad_oe low and pad_pull_en high. Pins whose sleep-policy bit is 1 keep their configured pad values.
- R8: Reads of the write-only aliases (0x04, 0x08, 0x14, 0x18) and of unmapped offsets return 0. A write to an unmapped offset changes no state. Offsets 0x0C, 0x1C, 0x20 and 0x24 read back what was written.
- R9: Sleep does not modify stored state. After sleep_req falls, pad_oe and the direction readback equal their values from before sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address; bits [5:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read strobe |
| pin_in | input | 32 | Pin levels seen at the pads |
| sleep_req | input | 1 | Sleep request |
| pad_oe | output | 32 | Output enable per pin |
| pad_out | output | 32 | Output value per pin |
| pad_pull_en | output | 32 | Pull resistor enable per pin |
| pad_pull_up | output | 32 | Pull direction per pin; 1 = up, 0 = down |
| pad_func | output | 64 | Function code, two bits per pin |

## Verification
The in-RTL assertions check the following on every cycle:
- set and clear alias writes land on pad_out, and direction-set writes land on pad_oe, in the following cycle;
- the synchronizer's second stage follows pin_in two cycles late;
- write-only aliases read as zero;
- no pin with a sleep-policy bit of 0 drives its pad during sleep.

Only the bench's scenarios can show the remaining behaviours:
- the two-bit function encoding;
- the pull direction following output data;
- configuration surviving a sleep period unchanged;
- unmapped writes having no effect;
- the exact reset values.

// File: rtl/gpio_pad_port.sv
module gpio_pad_port #(
  parameter int NPINS = 32,
  parameter int AW    = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [AW-1:0]      bus_addr,
  input  logic [NPINS-1:0]   bus_wdata,
  output logic [NPINS-1:0]   bus_rdata,
  input  logic [NPINS-1:0]   pin_in,
  input  logic               sleep_req,
  output logic [NPINS-1:0]   pad_oe,
  output logic [NPINS-1:0]   pad_out,
  output logic [NPINS-1:0]   pad_pull_en,
  output logic [NPINS-1:0]   pad_pull_up,
  output logic [2*NPINS-1:0] pad_func
);
  localparam int WW = AW - 2;
  localparam logic [WW-1:0] W_DATA = 0, W_DSET = 1, W_DCLR = 2, W_NOPULL = 3,
                            W_DIR = 4, W_DIRSET = 5, W_DIRCLR = 6, W_KEEP = 7,
                            W_FNA = 8, W_FNB = 9;

  logic [NPINS-1:0] out_q, dir_q, nopull_q, keep_q, fna_q, fnb_q, sync1_q, sync2_q;
  logic [WW-1:0] word;
  logic wr;

  assign word = bus_addr[AW-1:2];
  assign wr   = bus_sel && bus_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q    <= '0;
      dir_q    <= '0;
      nopull_q <= '0;
      keep_q   <= '0;
      fna_q    <= '0;
      fnb_q    <= '0;
    end else if (wr) begin
      case (word)
        W_DATA:   out_q    <= bus_wdata;
        W_DSET:   out_q    <= out_q | bus_wdata;
        W_DCLR:   out_q    <= out_q & ~bus_wdata;
        W_NOPULL: nopull_q <= bus_wdata;
        W_DIR:    dir_q    <= bus_wdata;
        W_DIRSET: dir_q    <= dir_q | bus_wdata;
        W_DIRCLR: dir_q    <= dir_q & ~bus_wdata;
        W_KEEP:   keep_q   <= bus_wdata;
        W_FNA:    fna_q    <= bus_wdata;
        W_FNB:    fnb_q    <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      case (word)
        W_DATA:   bus_rdata = sync2_q;
        W_NOPULL: bus_rdata = nopull_q;
        W_DIR:    bus_rdata = dir_q;
        W_KEEP:   bus_rdata = keep_q;
        W_FNA:    bus_rdata = fna_q;
        W_FNB:    bus_rdata = fnb_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  logic [NPINS-1:0] parked;
  assign parked      = sleep_req ? ~keep_q : '0;
  assign pad_oe      = dir_q & ~parked;
  assign pad_out     = out_q;
  assign pad_pull_en = ~nopull_q | parked;
  assign pad_pull_up = out_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_func
    assign pad_func[2*i+1:2*i] = {fnb_q[i], fna_q[i]};
  end

  logic [1:0] up_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_q <= '0;
    else if (up_q != 2'd3) up_q <= up_q + 2'd1;
  end

  // R2
  dset_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && word == W_DSET) |=> ((pad_out & $past(bus_wdata)) == $past(bus_wdata)));

  // R2
  dclr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && word == W_DCLR) |=> ((pad_out & $past(bus_wdata)) == '0));

  // R3
  dirset_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && word == W_DIRSET) |=> (sleep_req || ((pad_oe & $past(bus_wdata)) == $past(bus_wdata))));

  // R4
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q == 2'd3) |-> (sync2_q == $past(pin_in, 2)));

  // R8
  alias_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && (word == W_DSET || word == W_DCLR || word == W_DIRSET || word == W_DIRCLR))
      |-> (bus_rdata == '0));

  // R7
  sleep_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> ((pad_oe & ~keep_q) == '0));
endmodule

// File: tb/gpio_pad_port_tb.sv
module gpio_pad_port_tb;
  logic        clk = 0, rst_n = 0, bus_sel = 0, bus_we = 0, sleep_req = 0;
  logic [5:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, pin_in = 0;
  logic [31:0] bus_rdata, pad_oe, pad_out, pad_pull_en, pad_pull_up;
  logic [63:0] pad_func;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  gpio_pad_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .sleep_req(sleep_req),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pull_en(pad_pull_en),
    .pad_pull_up(pad_pull_up), .pad_func(pad_func));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #0.5 d = bus_rdata;
    bus_sel = 0;
  endtask

  typedef struct packed {
    logic [5:0]  wa; logic [31:0] wd; logic [5:0] ra; logic [31:0] re;
    logic [31:0] eout; logic [31:0] eoe;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VT [NV] = '{
    '{6'h04, 32'h0000_00F0, 6'h04, 32'h0,         32'h0000_00F0, 32'h0},
    '{6'h04, 32'h0000_000F, 6'h08, 32'h0,         32'h0000_00FF, 32'h0},
    '{6'h08, 32'h0000_003C, 6'h14, 32'h0,         32'h0000_00C3, 32'h0},
    '{6'h00, 32'hA5A5_0000, 6'h18, 32'h0,         32'hA5A5_0000, 32'h0},
    '{6'h14, 32'h0000_FFFF, 6'h10, 32'h0000_FFFF, 32'hA5A5_0000, 32'h0000_FFFF},
    '{6'h14, 32'hFF00_0000, 6'h10, 32'hFF00_FFFF, 32'hA5A5_0000, 32'hFF00_FFFF},
    '{6'h18, 32'h0000_0F0F, 6'h10, 32'hFF00_F0F0, 32'hA5A5_0000, 32'hFF00_F0F0},
    '{6'h10, 32'h1234_5679, 6'h10, 32'h1234_5679, 32'hA5A5_0000, 32'h1234_5679},
    '{6'h0C, 32'h0000_00FF, 6'h0C, 32'h0000_00FF, 32'hA5A5_0000, 32'h1234_5679},
    '{6'h1C, 32'h8000_0001, 6'h1C, 32'h8000_0001, 32'hA5A5_0000, 32'h1234_5679},
    '{6'h20, 32'h0000_0003, 6'h20, 32'h0000_0003, 32'hA5A5_0000, 32'h1234_5679},
    '{6'h24, 32'h0000_0006, 6'h24, 32'h0000_0006, 32'hA5A5_0000, 32'h1234_5679},
    '{6'h28, 32'hFFFF_FFFF, 6'h28, 32'h0,         32'hA5A5_0000, 32'h1234_5679}
  };

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    chk("R1 oe", pad_oe, 0);
    chk("R1 out", pad_out, 0);
    chk("R1 pull_en", pad_pull_en, 32'hFFFF_FFFF);
    chk("R1 func", pad_func, 0);
    rd(6'h1C, r); chk("R1 keep", r, 0);
    rd(6'h0C, r); chk("R1 nopull", r, 0);
    rd(6'h20, r); chk("R1 fna", r, 0);
    rd(6'h24, r); chk("R1 fnb", r, 0);

    // R2 R3 R8 vector walk
    for (int i = 0; i < NV; i++) begin
      wr(VT[i].wa, VT[i].wd);
      rd(VT[i].ra, r);
      chk($sformatf("R8 vec%0d read", i), r, VT[i].re);
      chk($sformatf("R2 vec%0d pad_out", i), pad_out, VT[i].eout);
      chk($sformatf("R3 vec%0d pad_oe", i), pad_oe, VT[i].eoe);
    end

    // R5 function codes for pins 0..3: 01, 11, 10, 00
    chk("R5 func", pad_func[7:0], 8'h2D);
    chk("R5 upper", pad_func[63:8], 0);
    // R6 pull enable and direction
    chk("R6 pull_en", pad_pull_en, 32'hFFFF_FF00);
    chk("R6 pull_up", pad_pull_up, 32'hA5A5_0000);
    wr(6'h04, 32'h0000_0100);
    chk("R6 pull_up follows data", pad_pull_up, 32'hA5A5_0100);

    // R7 sleep parks pins without keep bit
    @(negedge clk); sleep_req = 1; #0.5;
    chk("R7 oe sleep", pad_oe, 32'h0000_0001);
    chk("R7 pull_en sleep", pad_pull_en, 32'hFFFF_FFFE);
    chk("R7 out sleep", pad_out, 32'hA5A5_0100);
    @(negedge clk); sleep_req = 0; #0.5;
    // R9 state survives sleep
    chk("R9 oe after", pad_oe, 32'h1234_5679);
    rd(6'h10, r); chk("R9 dir after", r, 32'h1234_5679);
    chk("R9 pull_en after", pad_pull_en, 32'hFFFF_FF00);

    // R4 two-flop latency on data reads
    @(negedge clk); pin_in = 32'hDEAD_BEEF;
    @(negedge clk); rd(6'h00, r); chk("R4 one edge", r, 32'h0);
    @(negedge clk); rd(6'h00, r); chk("R4 two edges", r, 32'hDEAD_BEEF);
    @(negedge clk); pin_in = 32'h0F0F_0001;
    @(negedge clk); @(negedge clk); rd(6'h00, r); chk("R4 second pattern", r, 32'h0F0F_0001);

    // R1 reset mid-run
    @(negedge clk); rst_n = 0; #0.5;
    chk("R1 oe re-reset", pad_oe, 0);
    chk("R1 out re-reset", pad_out, 0);
    chk("R1 func re-reset", pad_func, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule